// File: doc/BRIEF.md
# Routing Switch Matrix for an Overlay Fabric

This block sits at every crossing of horizontal and vertical routing channels in a soft, overlay programmable fabric. Each of its four sides (left, top, right, bottom) carries `W` one-way input tracks and `W` one-way output tracks. Every output track is driven by its own four-way multiplexer, so the block holds `4*W` multiplexers. Each multiplexer has a 2-bit select, and all selects are held in one serial configuration chain of `8*W` flops.

Select value 0 behaves differently on different sides. On the left and bottom sides it drives the fabric's idle level, logic 1. On the top and right sides it copies the input of the same side and track back out. Because of this loopback, a pair of one-way wires can stand in for a two-way track. Select values 1 to 3 take the same-numbered track from one of the other three sides, walking clockwise.

The routing path is purely combinational. Configuration is shifted in on `clk` while `cfg_en` is high. The chain output `cfg_dout` lets several matrices be daisy-chained. These pins are plain control pins with no handshake, because the routing tracks are wires, not a stream.

Top module: `route_switch_matrix`

## Requirements
- R1: While and after reset, with no configuration loaded, every select is 0. Left and bottom outputs are all 1, and top and right outputs equal their own side's inputs.
- R2: On a left or bottom output whose select is 0, the output is 1 whatever any input carries.
- R3: On a top or right output whose select is 0, output track i equals input track i of the same side.
- R4: Select values are counted clockwise from the output's own side, with sides coded left=0, top=1, right=2, bottom=3. Select k (1 to 3) routes input side (own+k) mod 4.
- R5: Output track i only ever takes track i of the chosen side. Changing any other track index has no effect on it.
- R6: The chain word is `8*W` bits. The select of side s, track t sits in bits [2*(s*W+t)+1 : 2*(s*W+t)]. Each `clk` edge with `cfg_en` high shifts the word up by one and takes `cfg_din` into bit 0, so a word is loaded most significant bit first. Selects take effect as soon as their bits land.
- R7: With `cfg_en` low, a clock edge leaves every select unchanged, whatever `cfg_din` does.
- R8: `cfg_dout` always presents the top bit of the chain word. A word already in the chain therefore leaves `cfg_dout` most significant bit first while the next one is shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all selects |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_din | input | 1 | Serial configuration data in |
| cfg_dout | output | 1 | Serial configuration data out (top chain bit) |
| in_left | input | W | Left-side input tracks |
| in_top | input | W | Top-side input tracks |
| in_right | input | W | Right-side input tracks |
| in_bottom | input | W | Bottom-side input tracks |
| out_left | output | W | Left-side output tracks |
| out_top | output | W | Top-side output tracks |
| out_right | output | W | Right-side output tracks |
| out_bottom | output | W | Bottom-side output tracks |

## Verification
Configuration shifting and live routing share the same cycle. A word is never staged, so every shift edge changes the selects that the multiplexers are routing with at that moment. The bench holds non-trivial patterns on all four input sides while a word is loaded. At every shift step it compares all 4*W outputs and `cfg_dout` against a bench model of the partially shifted word. It also checks that the word before it is leaving on `cfg_dout` in order.

// File: rtl/route_switch_matrix_pkg.sv
package route_switch_matrix_pkg;
  localparam int NUM_SIDES = 4;
  localparam int SEL_W     = 2;

  typedef enum logic [1:0] {
    SIDE_LEFT   = 2'd0,
    SIDE_TOP    = 2'd1,
    SIDE_RIGHT  = 2'd2,
    SIDE_BOTTOM = 2'd3
  } side_e;

  // Sides whose position-0 choice is the fabric idle level rather than loopback
  function automatic bit side_idles_high(int side);
    return (side == int'(SIDE_LEFT)) || (side == int'(SIDE_BOTTOM));
  endfunction
endpackage

// File: rtl/rsm_cfg_chain.sv
module rsm_cfg_chain #(
  parameter int LEN = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] word,
  output logic           dout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (shift_en) word <= {word[LEN-2:0], din};
  end

  assign dout = word[LEN-1];
endmodule

// File: rtl/rsm_track_mux.sv
module rsm_track_mux #(
  parameter bit IDLE_HIGH = 1'b1
) (
  input  logic [1:0] sel,
  input  logic       own,
  input  logic       cw1,
  input  logic       cw2,
  input  logic       cw3,
  output logic       y
);
  logic pos0;

  generate
    if (IDLE_HIGH) begin : g_idle
      assign pos0 = 1'b1;
    end else begin : g_loop
      assign pos0 = own;
    end
  endgenerate

  always_comb begin
    case (sel)
      2'd0:    y = pos0;
      2'd1:    y = cw1;
      2'd2:    y = cw2;
      default: y = cw3;
    endcase
  end
endmodule

// File: rtl/route_switch_matrix.sv
module route_switch_matrix
  import route_switch_matrix_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic         cfg_dout,
  input  logic [W-1:0] in_left,
  input  logic [W-1:0] in_top,
  input  logic [W-1:0] in_right,
  input  logic [W-1:0] in_bottom,
  output logic [W-1:0] out_left,
  output logic [W-1:0] out_top,
  output logic [W-1:0] out_right,
  output logic [W-1:0] out_bottom
);
  localparam int CFG_LEN = NUM_SIDES * W * SEL_W;

  logic [CFG_LEN-1:0] cfg_word;
  logic [W-1:0]       in_side  [NUM_SIDES];
  logic [W-1:0]       out_side [NUM_SIDES];

  assign in_side[SIDE_LEFT]   = in_left;
  assign in_side[SIDE_TOP]    = in_top;
  assign in_side[SIDE_RIGHT]  = in_right;
  assign in_side[SIDE_BOTTOM] = in_bottom;

  assign out_left   = out_side[SIDE_LEFT];
  assign out_top    = out_side[SIDE_TOP];
  assign out_right  = out_side[SIDE_RIGHT];
  assign out_bottom = out_side[SIDE_BOTTOM];

  rsm_cfg_chain #(.LEN(CFG_LEN)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (cfg_en),
    .din      (cfg_din),
    .word     (cfg_word),
    .dout     (cfg_dout)
  );

  // Disjoint pattern: track t meets only track t of the other sides
  for (genvar s = 0; s < NUM_SIDES; s++) begin : g_side
    for (genvar t = 0; t < W; t++) begin : g_trk
      rsm_track_mux #(.IDLE_HIGH(side_idles_high(s))) u_mux (
        .sel (cfg_word[SEL_W*(s*W+t) +: SEL_W]),
        .own (in_side[s][t]),
        .cw1 (in_side[(s+1)%NUM_SIDES][t]),
        .cw2 (in_side[(s+2)%NUM_SIDES][t]),
        .cw3 (in_side[(s+3)%NUM_SIDES][t]),
        .y   (out_side[s][t])
      );
    end
  end
endmodule

// File: rtl/route_switch_matrix_chk.sv
module route_switch_matrix_chk #(
  parameter int W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_en,
  input logic           cfg_din,
  input logic [8*W-1:0] cfg_word,
  input logic [W-1:0]   in_top,
  input logic [W-1:0]   in_right,
  input logic [W-1:0]   out_left,
  input logic [W-1:0]   out_top,
  input logic [W-1:0]   out_right,
  input logic [W-1:0]   out_bottom
);
  // R1
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      reset_clear_chk: assert (cfg_word == '0);
    end
  end

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> $stable(cfg_word));

  // R6
  shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> cfg_word[0] == $past(cfg_din));

  for (genvar t = 0; t < W; t++) begin : g_trk
    // R2
    idle_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_word[2*t +: 2] == 2'd0) |-> out_left[t]);
    // R2
    idle_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_word[2*(3*W+t) +: 2] == 2'd0) |-> out_bottom[t]);
    // R3
    loop_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_word[2*(W+t) +: 2] == 2'd0) |-> out_top[t] == in_top[t]);
    // R3
    loop_right_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_word[2*(2*W+t) +: 2] == 2'd0) |-> out_right[t] == in_right[t]);
  end
endmodule

bind route_switch_matrix route_switch_matrix_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_en     (cfg_en),
  .cfg_din    (cfg_din),
  .cfg_word   (cfg_word),
  .in_top     (in_top),
  .in_right   (in_right),
  .out_left   (out_left),
  .out_top    (out_top),
  .out_right  (out_right),
  .out_bottom (out_bottom)
);

// File: tb/route_switch_matrix_bench.sv
`timescale 1ns/1ps
module route_switch_matrix_bench;
  localparam int W  = 4;
  localparam int CW = 8*W;
  typedef logic [4*W:0] obs_t; // {dout, bottom, right, top, left}

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cfg_en = 1'b0, cfg_din = 1'b0, done = 1'b0;
  logic [W-1:0] in_l = '0, in_t = '0, in_r = '0, in_b = '0;
  logic [W-1:0] o_l, o_t, o_r, o_b;
  logic cfg_dout;
  logic [CW-1:0] shadow = '0;
  obs_t  exp_q[$];
  string tag_q[$];
  int n_cmp = 0, n_bad = 0;

  route_switch_matrix #(.W(W)) u_route_switch_matrix (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_din(cfg_din),
    .cfg_dout(cfg_dout), .in_left(in_l), .in_top(in_t), .in_right(in_r),
    .in_bottom(in_b), .out_left(o_l), .out_top(o_t), .out_right(o_r),
    .out_bottom(o_b));

  function automatic logic [W-1:0] side_in(int s);
    case (s)
      0: return in_l;
      1: return in_t;
      2: return in_r;
      default: return in_b;
    endcase
  endfunction

  function automatic obs_t model();
    obs_t m;
    for (int s = 0; s < 4; s++) begin
      for (int t = 0; t < W; t++) begin
        logic [1:0] sel;
        logic [W-1:0] v;
        sel = shadow[2*(s*W+t) +: 2];
        if (sel == 2'd0) begin
          v = side_in(s);
          m[s*W+t] = (s == 0 || s == 3) ? 1'b1 : v[t];
        end else begin
          v = side_in((s + int'(sel)) % 4);
          m[s*W+t] = v[t];
        end
      end
    end
    m[4*W] = shadow[CW-1];
    return m;
  endfunction

  task automatic push(string tag);
    exp_q.push_back(model());
    tag_q.push_back(tag);
  endtask

  task automatic drive(logic [W-1:0] l, logic [W-1:0] t, logic [W-1:0] r,
                       logic [W-1:0] b, string tag);
    @(posedge clk); #1;
    in_l = l; in_t = t; in_r = r; in_b = b;
    push(tag);
  endtask

  task automatic load(logic [CW-1:0] word, string tag);
    for (int k = CW-1; k >= 0; k--) begin
      @(posedge clk);
      if (cfg_en) shadow = {shadow[CW-2:0], cfg_din};
      #1;
      push(tag);
      cfg_en = 1'b1;
      cfg_din = word[k];
    end
    @(posedge clk);
    shadow = {shadow[CW-2:0], cfg_din};
    #1;
    cfg_en = 1'b0;
    push(tag);
  endtask

  function automatic logic [CW-1:0] uniform(logic [1:0] l, logic [1:0] t,
                                            logic [1:0] r, logic [1:0] b);
    logic [CW-1:0] w;
    for (int i = 0; i < W; i++) begin
      w[2*i +: 2]         = l;
      w[2*(W+i) +: 2]     = t;
      w[2*(2*W+i) +: 2]   = r;
      w[2*(3*W+i) +: 2]   = b;
    end
    return w;
  endfunction

  // Monitor: compares every queued expectation at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      obs_t e, a;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      a  = {cfg_dout, o_b, o_r, o_t, o_l};
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", tg, a, e);
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: outputs during reset
    in_l = 4'h6; in_t = 4'h9; in_r = 4'h3; in_b = 4'hC;
    #1; push("R1 in reset");
    @(posedge clk); #1; rst_n = 1'b1;
    drive(4'h0, 4'hA, 4'h5, 4'h0, "R1 after reset");
    // R2 / R3: position 0 under varied inputs
    drive(4'h0, 4'h0, 4'h0, 4'h0, "R2 idle high, inputs low");
    drive(4'hF, 4'h3, 4'hC, 4'hF, "R3 loopback");
    // R4: each clockwise choice on every side
    for (int k = 1; k < 4; k++) begin
      load(uniform(2'(k), 2'(k), 2'(k), 2'(k)), "R6 load uniform");
      drive(4'h1, 4'h2, 4'h4, 4'h8, "R4 clockwise");
      drive(4'hE, 4'hD, 4'hB, 4'h7, "R4 clockwise inverse");
      drive(4'hA, 4'h5, 4'h0, 4'hF, "R4 clockwise mixed");
    end
    // R5: per-track selects with walking ones on each side
    begin
      logic [CW-1:0] w;
      for (int s = 0; s < 4; s++)
        for (int t = 0; t < W; t++)
          w[2*(s*W+t) +: 2] = 2'((s + t + 1) % 4);
      load(w, "R8 dout old word / R6 load");
      for (int t = 0; t < W; t++) begin
        drive(4'(1 << t), 4'h0, 4'h0, 4'h0, "R5 walk left");
        drive(4'h0, 4'(1 << t), 4'h0, 4'h0, "R5 walk top");
        drive(4'h0, 4'h0, 4'(1 << t), 4'h0, "R5 walk right");
        drive(4'h0, 4'h0, 4'h0, 4'(1 << t), "R5 walk bottom");
      end
    end
    // R7: cfg_din toggles with enable low
    for (int n = 0; n < 10; n++) begin
      @(posedge clk); #1;
      cfg_din = ~cfg_din;
      in_t = in_t ^ 4'h5;
      push("R7 hold with enable low");
    end
    // R8: shift a fresh word, old word appears on cfg_dout
    load({CW/2{2'b01}}, "R8 dout stream");
    load(uniform(2'd0, 2'd0, 2'd0, 2'd0), "R8 dout stream back to zero");
    drive(4'h5, 4'hA, 4'h3, 4'h6, "R2 R3 after reload to zero");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule